// File: doc/BRIEF.md
# Port Data Word and Condition Flag Unit

This block keeps the data word of a programmable network port together with three single-bit condition flags. The data word can be built from literals in two ways. A wide shift pushes a 19-bit immediate in at the bottom and moves the older low bits upward. A narrow load writes a 13-bit immediate and fills the bits above it with zeros or with ones. A capture strobe instead copies a whole incoming 37-bit word into the register.

Flags A and B are rewritten together by a flag operation. Each flag has its own 6-bit mask that picks terms from the current flags and their complements, and the new value is the OR of the picked terms. Flag C changes only on a move operation. It takes either the signal bit of the arriving packet or a value supplied by the attached unit. A parameter selects whether the unit sits on the input side or the output side of the port, and that choice sets which source C uses. An outside decoder supplies one-cycle operation strobes. Sequencing and loop counting are handled elsewhere.

Top module: `dock_latch_flags`

## Requirements
- R1: After reset, `dataWord`, `flagA`, `flagB` and `flagC` are all zero.
- R2: When `opShift` is high, the next `dataWord` is `{old dataWord[17:0], immShift[18:0]}`.
- R3: When `opLoadLit` is high, the next `dataWord[12:0]` is `immLit`. Bits 36:13 become all ones if `litOnes` is 1 and all zeros if it is 0.
- R4: When `opCapture` is high, the next `dataWord` equals `inWord`. At most one of `opShift`, `opLoadLit` and `opCapture` is high in any cycle.
- R5: When `opFlags` is high, each new flag value is the OR of the terms its mask selects. Mask bit 5 selects A, bit 4 selects not-A, bit 3 selects B, bit 2 selects not-B, bit 1 selects C and bit 0 selects not-C. `maskA` gives the new A and `maskB` gives the new B.
- R6: A mask of zero gives 0. A mask that selects a flag and its complement gives 1. A mask that selects only the flag's own term leaves that flag unchanged.
- R7: Both new A and new B are computed from the flag values held before the update, so a swap mask exchanges A and B in one cycle.
- R8: With `OUTPUT_SIDE`=0, a move with `moveDataIn` or `moveTokenIn` set loads `inSignal` into C.
- R9: With `OUTPUT_SIDE`=1, a move with `moveDataIn` set loads `unitFlag` into C. A move with only `moveTokenIn` set loads `inSignal` into C.
- R10: In a cycle with no data strobe, `dataWord` holds its value. With no flag operation, A and B hold. A move with neither `moveDataIn` nor `moveTokenIn` set, or no move at all, leaves C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opShift | input | 1 | Shift the wide immediate into the data word |
| immShift | input | 19 | Immediate for shift |
| opLoadLit | input | 1 | Load the extended narrow immediate |
| immLit | input | 13 | Narrow immediate |
| litOnes | input | 1 | Extension fill: 1 fills with ones, 0 fills with zeros |
| opCapture | input | 1 | Capture the incoming word |
| inWord | input | 37 | Incoming data word |
| opFlags | input | 1 | Rewrite A and B from the masks |
| maskA | input | 6 | Term mask for new A |
| maskB | input | 6 | Term mask for new B |
| opMove | input | 1 | Move operation executes this cycle |
| moveDataIn | input | 1 | Move has its data-in bit set |
| moveTokenIn | input | 1 | Move has its token-in bit set |
| inSignal | input | 1 | Signal bit of the incoming packet |
| unitFlag | input | 1 | Condition value supplied by the attached unit |
| dataWord | output | 37 | Data word register |
| flagA | output | 1 | Flag A |
| flagB | output | 1 | Flag B |
| flagC | output | 1 | Flag C |

## Verification
The properties assume that the decoder never raises two of the shift, load and capture strobes in the same cycle. One property checks this assumption directly. The bench drives each operation through its own task, and each task clears every strobe before it raises one, so the stimulus stays within the assumption. Flag operations and moves may fall in the same cycle because they write disjoint state. The bench builds two instances, one for each port side, so that every C check runs against both source selections.

// File: rtl/dock_lf_pkg.sv
package dock_lf_pkg;
  localparam int MASK_W = 6;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_SHIFT = 2'd1,
    SRC_LIT   = 2'd2,
    SRC_CAPT  = 2'd3
  } dataSrc_e;

  typedef struct packed {
    dataSrc_e dataSrc;
    logic     flagWe;
    logic     cWe;
    logic     cFromUnit;
  } dockCtl_t;
endpackage

// File: rtl/dock_lf_ctrl.sv
module dock_lf_ctrl
  import dock_lf_pkg::*;
#(
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input  logic     opShift,
  input  logic     opLoadLit,
  input  logic     opCapture,
  input  logic     opFlags,
  input  logic     opMove,
  input  logic     moveDataIn,
  input  logic     moveTokenIn,
  output dockCtl_t ctl
);
  logic cSel;

  generate
    if (OUTPUT_SIDE) begin : g_outSide
      assign cSel = moveDataIn;
    end else begin : g_inSide
      assign cSel = 1'b0;
    end
  endgenerate

  always_comb begin
    ctl = '0;
    if (opShift)        ctl.dataSrc = SRC_SHIFT;
    else if (opLoadLit) ctl.dataSrc = SRC_LIT;
    else if (opCapture) ctl.dataSrc = SRC_CAPT;
    else                ctl.dataSrc = SRC_HOLD;
    ctl.flagWe    = opFlags;
    ctl.cWe       = opMove & (moveDataIn | moveTokenIn);
    ctl.cFromUnit = cSel;
  end
endmodule

// File: rtl/dock_lf_datapath.sv
module dock_lf_datapath
  import dock_lf_pkg::*;
#(
  parameter int DATA_W  = 37,
  parameter int SHIFT_W = 19,
  parameter int LIT_W   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dockCtl_t          ctl,
  input  logic [SHIFT_W-1:0] immShift,
  input  logic [LIT_W-1:0]  immLit,
  input  logic              litOnes,
  input  logic [DATA_W-1:0] inWord,
  input  logic [MASK_W-1:0] maskA,
  input  logic [MASK_W-1:0] maskB,
  input  logic              inSignal,
  input  logic              unitFlag,
  output logic [DATA_W-1:0] dataWord,
  output logic              flagA,
  output logic              flagB,
  output logic              flagC
);
  localparam int KEEP_W = DATA_W - SHIFT_W;
  localparam int EXT_W  = DATA_W - LIT_W;

  logic [DATA_W-1:0] dataNext;
  logic [MASK_W-1:0] terms;
  logic              nextA, nextB, nextC;

  always_comb begin
    case (ctl.dataSrc)
      SRC_SHIFT: dataNext = {dataWord[KEEP_W-1:0], immShift};
      SRC_LIT:   dataNext = {{EXT_W{litOnes}}, immLit};
      SRC_CAPT:  dataNext = inWord;
      default:   dataNext = dataWord;
    endcase
  end

  assign terms = {flagA, ~flagA, flagB, ~flagB, flagC, ~flagC};
  assign nextA = ctl.flagWe ? |(maskA & terms) : flagA;
  assign nextB = ctl.flagWe ? |(maskB & terms) : flagB;
  assign nextC = ctl.cWe ? (ctl.cFromUnit ? unitFlag : inSignal) : flagC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataWord <= '0;
      flagA    <= 1'b0;
      flagB    <= 1'b0;
      flagC    <= 1'b0;
    end else begin
      dataWord <= dataNext;
      flagA    <= nextA;
      flagB    <= nextB;
      flagC    <= nextC;
    end
  end
endmodule

// File: rtl/dock_latch_flags.sv
module dock_latch_flags
  import dock_lf_pkg::*;
#(
  parameter int DATA_W      = 37,
  parameter int SHIFT_W     = 19,
  parameter int LIT_W       = 13,
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opShift,
  input  logic [SHIFT_W-1:0] immShift,
  input  logic              opLoadLit,
  input  logic [LIT_W-1:0]  immLit,
  input  logic              litOnes,
  input  logic              opCapture,
  input  logic [DATA_W-1:0] inWord,
  input  logic              opFlags,
  input  logic [5:0]        maskA,
  input  logic [5:0]        maskB,
  input  logic              opMove,
  input  logic              moveDataIn,
  input  logic              moveTokenIn,
  input  logic              inSignal,
  input  logic              unitFlag,
  output logic [DATA_W-1:0] dataWord,
  output logic              flagA,
  output logic              flagB,
  output logic              flagC
);
  dockCtl_t ctl;

  dock_lf_ctrl #(.OUTPUT_SIDE(OUTPUT_SIDE)) u_ctrl (
    .opShift(opShift), .opLoadLit(opLoadLit), .opCapture(opCapture),
    .opFlags(opFlags), .opMove(opMove), .moveDataIn(moveDataIn),
    .moveTokenIn(moveTokenIn), .ctl(ctl)
  );

  dock_lf_datapath #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .LIT_W(LIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immShift(immShift), .immLit(immLit),
    .litOnes(litOnes), .inWord(inWord), .maskA(maskA), .maskB(maskB),
    .inSignal(inSignal), .unitFlag(unitFlag), .dataWord(dataWord),
    .flagA(flagA), .flagB(flagB), .flagC(flagC)
  );
endmodule

// File: rtl/dock_latch_flags_chk.sv
module dock_latch_flags_chk #(
  parameter int DATA_W      = 37,
  parameter int SHIFT_W     = 19,
  parameter int LIT_W       = 13,
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              opShift,
  input logic [SHIFT_W-1:0] immShift,
  input logic              opLoadLit,
  input logic [LIT_W-1:0]  immLit,
  input logic              litOnes,
  input logic              opCapture,
  input logic [DATA_W-1:0] inWord,
  input logic              opFlags,
  input logic [5:0]        maskA,
  input logic [5:0]        maskB,
  input logic              opMove,
  input logic              moveDataIn,
  input logic              moveTokenIn,
  input logic              inSignal,
  input logic              unitFlag,
  input logic [DATA_W-1:0] dataWord,
  input logic              flagA,
  input logic              flagB,
  input logic              flagC
);
  localparam int KEEP_W = DATA_W - SHIFT_W;
  localparam int EXT_W  = DATA_W - LIT_W;

  p_ops_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones({opShift, opLoadLit, opCapture}) <= 1);

  p_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    opShift |=> dataWord == {$past(dataWord[KEEP_W-1:0]), $past(immShift)});

  p_lit_r3: assert property (@(posedge clk) disable iff (!rstN)
    opLoadLit |=> dataWord == {{EXT_W{$past(litOnes)}}, $past(immLit)});

  p_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    opCapture |=> dataWord == $past(inWord));

  p_flag_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    opFlags |=> flagA == |($past(maskA) & {$past(flagA), ~$past(flagA),
                 $past(flagB), ~$past(flagB), $past(flagC), ~$past(flagC)}));

  p_flag_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    opFlags |=> flagB == |($past(maskB) & {$past(flagA), ~$past(flagA),
                 $past(flagB), ~$past(flagB), $past(flagC), ~$past(flagC)}));

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(opShift || opLoadLit || opCapture) |=> $stable(dataWord));

  p_ab_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opFlags |=> $stable(flagA) && $stable(flagB));

  p_c_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(opMove && (moveDataIn || moveTokenIn)) |=> $stable(flagC));

  generate
    if (OUTPUT_SIDE) begin : g_outChk
      p_c_unit_r9: assert property (@(posedge clk) disable iff (!rstN)
        (opMove && moveDataIn) |=> flagC == $past(unitFlag));
      p_c_token_r9: assert property (@(posedge clk) disable iff (!rstN)
        (opMove && !moveDataIn && moveTokenIn) |=> flagC == $past(inSignal));
    end else begin : g_inChk
      p_c_signal_r8: assert property (@(posedge clk) disable iff (!rstN)
        (opMove && (moveDataIn || moveTokenIn)) |=> flagC == $past(inSignal));
    end
  endgenerate
endmodule

bind dock_latch_flags dock_latch_flags_chk #(
  .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .LIT_W(LIT_W), .OUTPUT_SIDE(OUTPUT_SIDE)
) u_chk (
  .clk(clk), .rstN(rstN), .opShift(opShift), .immShift(immShift),
  .opLoadLit(opLoadLit), .immLit(immLit), .litOnes(litOnes),
  .opCapture(opCapture), .inWord(inWord), .opFlags(opFlags),
  .maskA(maskA), .maskB(maskB), .opMove(opMove), .moveDataIn(moveDataIn),
  .moveTokenIn(moveTokenIn), .inSignal(inSignal), .unitFlag(unitFlag),
  .dataWord(dataWord), .flagA(flagA), .flagB(flagB), .flagC(flagC)
);

// File: tb/sim_dock_latch_flags.sv
`timescale 1ns/1ps
module sim_dock_latch_flags;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opShift = 0, opLoadLit = 0, litOnes = 0, opCapture = 0;
  logic        opFlags = 0, opMove = 0, moveDataIn = 0, moveTokenIn = 0;
  logic        inSignal = 0, unitFlag = 0;
  logic [18:0] immShift = '0;
  logic [12:0] immLit = '0;
  logic [36:0] inWord = '0;
  logic [5:0]  maskA = '0, maskB = '0;
  logic [36:0] dw0, dw1;
  logic        a0, b0, c0, a1, b1, c1;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [36:0] d;
    logic        a0, b0, c0, a1, b1, c1;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic [36:0] mData = '0;
  logic        mA[2] = '{1'b0, 1'b0};
  logic        mB[2] = '{1'b0, 1'b0};
  logic        mC[2] = '{1'b0, 1'b0};

  always #4 clk = ~clk;

  dock_latch_flags #(.OUTPUT_SIDE(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .opShift(opShift), .immShift(immShift),
    .opLoadLit(opLoadLit), .immLit(immLit), .litOnes(litOnes),
    .opCapture(opCapture), .inWord(inWord), .opFlags(opFlags),
    .maskA(maskA), .maskB(maskB), .opMove(opMove), .moveDataIn(moveDataIn),
    .moveTokenIn(moveTokenIn), .inSignal(inSignal), .unitFlag(unitFlag),
    .dataWord(dw0), .flagA(a0), .flagB(b0), .flagC(c0));

  dock_latch_flags #(.OUTPUT_SIDE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .opShift(opShift), .immShift(immShift),
    .opLoadLit(opLoadLit), .immLit(immLit), .litOnes(litOnes),
    .opCapture(opCapture), .inWord(inWord), .opFlags(opFlags),
    .maskA(maskA), .maskB(maskB), .opMove(opMove), .moveDataIn(moveDataIn),
    .moveTokenIn(moveTokenIn), .inSignal(inSignal), .unitFlag(unitFlag),
    .dataWord(dw1), .flagA(a1), .flagB(b1), .flagC(c1));

  // R5 term order: bit5 A, bit4 ~A, bit3 B, bit2 ~B, bit1 C, bit0 ~C
  function automatic logic pick(input logic [5:0] m, input logic a, input logic b,
                                input logic c);
    logic r = 1'b0;
    if (m[5] && a)  r = 1'b1;
    if (m[4] && !a) r = 1'b1;
    if (m[3] && b)  r = 1'b1;
    if (m[2] && !b) r = 1'b1;
    if (m[1] && c)  r = 1'b1;
    if (m[0] && !c) r = 1'b1;
    return r;
  endfunction

  task automatic clearOps();
    opShift = 0; opLoadLit = 0; opCapture = 0; opFlags = 0;
    opMove = 0; moveDataIn = 0; moveTokenIn = 0;
  endtask

  task automatic pushExp(input string tag);
    exp_t e;
    e.d = mData; e.tag = tag;
    e.a0 = mA[0]; e.b0 = mB[0]; e.c0 = mC[0];
    e.a1 = mA[1]; e.b1 = mB[1]; e.c1 = mC[1];
    expQ.push_back(e);
  endtask

  task automatic doShift(input logic [18:0] imm, input string tag);
    @(negedge clk); clearOps();
    opShift = 1; immShift = imm;
    mData = {mData[17:0], imm};
    pushExp(tag);
  endtask

  task automatic doLit(input logic ones, input logic [12:0] imm, input string tag);
    @(negedge clk); clearOps();
    opLoadLit = 1; litOnes = ones; immLit = imm;
    mData = {{24{ones}}, imm};
    pushExp(tag);
  endtask

  task automatic doCapture(input logic [36:0] w, input string tag);
    @(negedge clk); clearOps();
    opCapture = 1; inWord = w;
    mData = w;
    pushExp(tag);
  endtask

  task automatic doFlags(input logic [5:0] ma, input logic [5:0] mb, input string tag);
    @(negedge clk); clearOps();
    opFlags = 1; maskA = ma; maskB = mb;
    for (int i = 0; i < 2; i++) begin
      logic na, nb;
      na = pick(ma, mA[i], mB[i], mC[i]);
      nb = pick(mb, mA[i], mB[i], mC[i]);
      mA[i] = na; mB[i] = nb;
    end
    pushExp(tag);
  endtask

  task automatic doMove(input logic di, input logic ti, input logic sig,
                        input logic uf, input string tag);
    @(negedge clk); clearOps();
    opMove = 1; moveDataIn = di; moveTokenIn = ti; inSignal = sig; unitFlag = uf;
    if (di || ti) mC[0] = sig;          // R8 input side
    if (di) mC[1] = uf;                 // R9 output side
    else if (ti) mC[1] = sig;
    pushExp(tag);
  endtask

  task automatic doIdle(input string tag);
    @(negedge clk); clearOps();
    immShift = 19'h7FFFF; immLit = 13'h1FFF; inWord = '1; maskA = 6'h3F;
    maskB = 6'h3F; inSignal = ~inSignal; unitFlag = ~unitFlag;
    pushExp(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (dw0 !== e.d || dw1 !== e.d || a0 !== e.a0 || b0 !== e.b0 || c0 !== e.c0 ||
            a1 !== e.a1 || b1 !== e.b1 || c1 !== e.c1) begin
          errors++;
          $display("FAIL %s: actual d0=%h d1=%h abc0=%b%b%b abc1=%b%b%b expected d=%h abc0=%b%b%b abc1=%b%b%b",
                   e.tag, dw0, dw1, a0, b0, c0, a1, b1, c1,
                   e.d, e.a0, e.b0, e.c0, e.a1, e.b1, e.c1);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (dw0 !== '0 || dw1 !== '0 || {a0, b0, c0, a1, b1, c1} !== 6'b0) begin
      errors++;
      $display("FAIL R1: actual d0=%h d1=%h flags=%b%b%b%b%b%b expected all zero",
               dw0, dw1, a0, b0, c0, a1, b1, c1);
    end

    doShift(19'h5A5A5, "R2 first shift");
    doShift(19'h12345, "R2 second shift");
    for (int k = 0; k < 4; k++) doShift(19'h0F0F0 ^ (19'(k) * 19'h11111), "R2 shift chain");
    doIdle("R10 data hold after shift");
    doLit(1'b0, 13'h1ABC, "R3 zero extend");
    doLit(1'b1, 13'h0055, "R3 one extend");
    doCapture(37'h1_2345_6789, "R4 capture");
    doIdle("R10 hold after capture");
    doShift(19'h40001, "R2 shift after capture");

    doMove(1'b1, 1'b0, 1'b1, 1'b0, "R8 R9 data-in move");
    doFlags(6'b110000, 6'b000000, "R6 A|~A gives 1, zero mask gives 0");
    doFlags(6'b100000, 6'b001100, "R6 self mask holds A, B|~B gives 1");
    doFlags(6'b100000, 6'b000000, "R6 set B to 0 keeping A");
    doFlags(6'b001000, 6'b100000, "R7 swap A and B");
    doFlags(6'b000010, 6'b000001, "R5 C and not-C terms");
    doFlags(6'b010100, 6'b011000, "R5 mixed terms");
    doIdle("R10 flags hold");
    doMove(1'b0, 1'b1, 1'b0, 1'b1, "R8 R9 token-in move uses signal");
    doMove(1'b1, 1'b1, 1'b1, 1'b0, "R9 data-in wins over token-in");
    doMove(1'b1, 1'b1, 1'b0, 1'b1, "R8 R9 both bits set");
    doMove(1'b0, 1'b0, 1'b0, 1'b0, "R10 move without in bits leaves C");
    doMove(1'b0, 1'b1, 1'b1, 1'b0, "R8 R9 token-in sets C");
    doFlags(6'b000011, 6'b100010, "R6 C|~C gives 1");
    doIdle("R10 final hold");

    @(negedge clk); clearOps();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule